// File: doc/BRIEF.md
# DDR2 Mode Register Timing Controller

This block sits inside a DDR2 memory controller. It watches every load-mode-register command the controller sends, decodes the parts of the 13-bit mode value that affect timing, and keeps them in its own registers. From those fields it enforces three rules.

First, after a DLL reset it withholds permission to read until the DLL has had time to lock. Second, for a write with auto precharge it counts the programmed write-recovery time before it issues the internal precharge. Third, it tells the power-down logic whether leaving active power-down must use the slow-exit timing.

A mode value that selects the manufacturer test mode, or that carries a reserved write-recovery code, raises an error flag. In both cases the affected settings keep their previous values.

The DLL-reset bit is held only for the cycle in which the block emits its reset pulse, and then clears itself. After reset the block starts with reads blocked and with the shortest legal write recovery. Reads stay blocked until the controller has issued an initial DLL reset and the lock wait has run out.

Top module: `ddr2_mrs_ctrl`

## Requirements
- R1: After reset, rd_allow, rd_go, dll_rst, ap_pulse, err_test, err_rsvd and pd_exit_slow are 0, and write recovery is 2 clocks.
- R2: A mode write with bit 7 set is a test-mode write. It sets err_test from the next cycle on. It changes no other field: write recovery, the power-down bit and err_rsvd keep their values, and no DLL reset starts even if bit 8 is set.
- R3: A mode write with bit 7 clear is a normal write. It clears err_test and stores bit 12 as the power-down exit bit.
- R4: A normal write with bit 8 set makes dll_rst high for exactly one cycle, the cycle after the edge that accepts the write, and the stored request then returns to 0 by itself.
- R5: rd_allow is 0 from the edge that accepts a normal write with bit 8 set. It returns to 1 exactly LOCK_CYC+1 clock edges after that edge, which is LOCK_CYC cycles after the dll_rst pulse (default 200). rd_go equals rd_req while rd_allow is 1 and is 0 otherwise.
- R6: A normal write without bit 8 that arrives during the lock wait does not change when rd_allow rises. A normal write with bit 8 that arrives during the wait restarts the wait from that write.
- R7: Bits 11:9 encode write recovery: code 1 to 5 mean 2 to 6 clocks. If burst_end is sampled while a write-with-auto-precharge request is pending (wap_req in an earlier cycle or the same cycle), ap_pulse is high for one cycle, starting exactly WR edges after the burst_end edge.
- R8: A normal write with code 0, 6 or 7 in bits 11:9 sets err_rsvd and leaves the write-recovery value unchanged. A normal write with a legal code clears err_rsvd.
- R9: burst_end with no pending write-with-auto-precharge request produces no ap_pulse.
- R10: pd_exit_slow is the stored bit 12 when act_pd is 1 (at least one bank open), and is 0 when act_pd is 0 (precharge power-down).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mr_we | input | 1 | Load-mode-register command strobe |
| mr_val | input | 13 | Mode value carried by the command |
| rd_req | input | 1 | READ command request |
| wap_req | input | 1 | WRITE with auto precharge request |
| burst_end | input | 1 | Last data of the current write burst |
| act_pd | input | 1 | 1 when power-down would be active power-down |
| rd_allow | output | 1 | READ commands permitted |
| rd_go | output | 1 | READ request granted this cycle |
| dll_rst | output | 1 | One-cycle DLL reset pulse |
| ap_pulse | output | 1 | Internal auto-precharge issue pulse |
| pd_exit_slow | output | 1 | Slow-exit timing applies to power-down exit |
| err_test | output | 1 | Last mode write selected test mode |
| err_rsvd | output | 1 | Last normal write held a reserved WR code |

## Verification
The hardest case to reach is a mode write that lands inside a running 200-cycle lock wait. At that point the bench must tell a restart of the counter apart from an undisturbed count. The bench counts clock edges itself and places a second write, once with bit 8 and once without, at a known distance after the first. It then compares the edge on which rd_allow rises with the edge predicted from whichever write should own the wait. Reserved and test-mode codes are placed in a vector table right after legal codes, so that a value that is wrongly kept or wrongly overwritten shows up in the next measured recovery time.

// File: rtl/ddr2_mrs_pkg.sv
package ddr2_mrs_pkg;

    localparam int MR_W     = 13;
    localparam int TEST_POS = 7;
    localparam int DLL_POS  = 8;
    localparam int WR_LSB   = 9;
    localparam int WR_MSB   = 11;
    localparam int PD_POS   = 12;
    localparam int WR_W     = WR_MSB - WR_LSB + 1;
    localparam logic [WR_W-1:0] WR_MIN = WR_W'(2);
    localparam logic [WR_W-1:0] CODE_LO = WR_W'(1);
    localparam logic [WR_W-1:0] CODE_HI = WR_W'(5);

    typedef struct packed {
        logic            is_test;
        logic            dll_req;
        logic            wr_ok;
        logic [WR_W-1:0] wr_clk;
        logic            pd_slow;
    } mr_dec_t;

endpackage

// File: rtl/mrs_decode.sv
module mrs_decode
    import ddr2_mrs_pkg::*;
(
    input  logic [PD_POS:TEST_POS] mr_hi,
    output mr_dec_t                dec
);
    logic [WR_W-1:0] code;

    always_comb begin
        code        = mr_hi[WR_MSB:WR_LSB];
        dec.is_test = mr_hi[TEST_POS];
        dec.dll_req = mr_hi[DLL_POS];
        dec.pd_slow = mr_hi[PD_POS];
        dec.wr_ok   = (code >= CODE_LO) && (code <= CODE_HI);
        dec.wr_clk  = code + WR_W'(1);
    end
endmodule

// File: rtl/mrs_field_regs.sv
module mrs_field_regs
    import ddr2_mrs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mr_we,
    input  mr_dec_t         dec,
    output logic [WR_W-1:0] wr_clk,
    output logic            pd_bit,
    output logic            dll_bit,
    output logic            err_test,
    output logic            err_rsvd
);
    typedef struct packed {
        logic [WR_W-1:0] wr_clk;
        logic            pd_bit;
        logic            dll_bit;
        logic            err_test;
        logic            err_rsvd;
    } fld_t;

    fld_t fld_d, fld_q;

    always_comb begin
        fld_d         = fld_q;
        fld_d.dll_bit = 1'b0;
        if (mr_we) begin
            if (dec.is_test) begin
                fld_d.err_test = 1'b1;
            end else begin
                fld_d.err_test = 1'b0;
                fld_d.pd_bit   = dec.pd_slow;
                fld_d.dll_bit  = dec.dll_req;
                if (dec.wr_ok) begin
                    fld_d.wr_clk   = dec.wr_clk;
                    fld_d.err_rsvd = 1'b0;
                end else begin
                    fld_d.err_rsvd = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q <= '{wr_clk: WR_MIN, default: '0};
        end else begin
            fld_q <= fld_d;
        end
    end

    assign wr_clk   = fld_q.wr_clk;
    assign pd_bit   = fld_q.pd_bit;
    assign dll_bit  = fld_q.dll_bit;
    assign err_test = fld_q.err_test;
    assign err_rsvd = fld_q.err_rsvd;
endmodule

// File: rtl/dll_lock_timer.sv
module dll_lock_timer #(
    parameter int LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dll_req_now,
    input  logic dll_pulse,
    output logic rd_ok
);
    localparam int CNT_W = (LOCK_CYC > 2) ? $clog2(LOCK_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             ok;
    } lk_t;

    lk_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (dll_req_now) begin
            lk_d.ok  = 1'b0;
            lk_d.run = 1'b0;
        end else if (dll_pulse) begin
            lk_d.run = 1'b1;
            lk_d.cnt = CNT_LOAD;
        end else if (lk_q.run) begin
            if (lk_q.cnt == '0) begin
                lk_d.run = 1'b0;
                lk_d.ok  = 1'b1;
            end else begin
                lk_d.cnt = lk_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign rd_ok = lk_q.ok;
endmodule

// File: rtl/wr_recovery_timer.sv
module wr_recovery_timer
    import ddr2_mrs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wap_req,
    input  logic            burst_end,
    input  logic [WR_W-1:0] wr_clk,
    output logic            ap_pulse
);
    typedef struct packed {
        logic            armed;
        logic            run;
        logic [WR_W-1:0] cnt;
        logic            ap;
    } wt_t;

    wt_t wt_d, wt_q;
    logic pending;

    always_comb begin
        wt_d       = wt_q;
        wt_d.ap    = 1'b0;
        pending    = wt_q.armed | wap_req;
        wt_d.armed = pending;
        if (wt_q.run) begin
            if (wt_q.cnt == '0) begin
                wt_d.run = 1'b0;
                wt_d.ap  = 1'b1;
            end else begin
                wt_d.cnt = wt_q.cnt - WR_W'(1);
            end
        end
        if (burst_end && pending) begin
            wt_d.armed = 1'b0;
            wt_d.run   = 1'b1;
            wt_d.cnt   = wr_clk - WR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wt_q <= '0;
        end else begin
            wt_q <= wt_d;
        end
    end

    assign ap_pulse = wt_q.ap;
endmodule

// File: rtl/ddr2_mrs_ctrl.sv
module ddr2_mrs_ctrl
    import ddr2_mrs_pkg::*;
#(
    parameter int LOCK_CYC = 200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mr_we,
    input  logic [MR_W-1:0] mr_val,
    input  logic            rd_req,
    input  logic            wap_req,
    input  logic            burst_end,
    input  logic            act_pd,
    output logic            rd_allow,
    output logic            rd_go,
    output logic            dll_rst,
    output logic            ap_pulse,
    output logic            pd_exit_slow,
    output logic            err_test,
    output logic            err_rsvd
);
    mr_dec_t         dec;
    logic [WR_W-1:0] wr_clk_q;
    logic            pd_bit_q;
    logic            dll_req_now;

    mrs_decode u_dec (
        .mr_hi (mr_val[PD_POS:TEST_POS]),
        .dec   (dec)
    );

    mrs_field_regs u_fld (
        .clk      (clk),
        .rst_n    (rst_n),
        .mr_we    (mr_we),
        .dec      (dec),
        .wr_clk   (wr_clk_q),
        .pd_bit   (pd_bit_q),
        .dll_bit  (dll_rst),
        .err_test (err_test),
        .err_rsvd (err_rsvd)
    );

    assign dll_req_now = mr_we & ~dec.is_test & dec.dll_req;

    dll_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .dll_req_now (dll_req_now),
        .dll_pulse   (dll_rst),
        .rd_ok       (rd_allow)
    );

    wr_recovery_timer u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wap_req   (wap_req),
        .burst_end (burst_end),
        .wr_clk    (wr_clk_q),
        .ap_pulse  (ap_pulse)
    );

    assign rd_go        = rd_req & rd_allow;
    assign pd_exit_slow = pd_bit_q & act_pd;
endmodule

// File: rtl/ddr2_mrs_chk.sv
module ddr2_mrs_chk #(
    parameter int LOCK_CYC = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mr_we,
    input logic       bit_test,
    input logic       bit_dll,
    input logic       dll_rst,
    input logic       rd_allow,
    input logic       ap_pulse,
    input logic       err_test,
    input logic [2:0] wr_clk
);
    localparam int SW = $clog2(LOCK_CYC + 2);
    localparam logic [SW-1:0] SAT = SW'(LOCK_CYC + 1);

    logic [SW-1:0] since_d, since_q;

    always_comb begin
        since_d = since_q;
        if (dll_rst) since_d = '0;
        else if (since_q < SAT) since_d = since_q + SW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) since_q <= '0;
        else since_q <= since_d;
    end

    p_test_hold_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mr_we && bit_test |=> $stable(wr_clk));
    p_test_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mr_we && bit_test |=> err_test);
    p_dll_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dll_rst |=> !dll_rst);
    p_dll_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mr_we && !bit_test && bit_dll |=> dll_rst && !rd_allow);
    p_lock_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_allow) |-> since_q >= SW'(LOCK_CYC));
    p_ap_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ap_pulse |=> !ap_pulse);
    p_wr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clk >= 3'd2 && wr_clk <= 3'd6);
endmodule

bind ddr2_mrs_ctrl ddr2_mrs_chk #(.LOCK_CYC(LOCK_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mr_we    (mr_we),
    .bit_test (mr_val[7]),
    .bit_dll  (mr_val[8]),
    .dll_rst  (dll_rst),
    .rd_allow (rd_allow),
    .ap_pulse (ap_pulse),
    .err_test (err_test),
    .wr_clk   (wr_clk_q)
);

// File: tb/sim_ddr2_mrs_ctrl.sv
module sim_ddr2_mrs_ctrl;
    localparam int LOCK = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mr_we = 1'b0;
    logic [12:0] mr_val = '0;
    logic        rd_req = 1'b0, wap_req = 1'b0, burst_end = 1'b0, act_pd = 1'b0;
    logic        rd_allow, rd_go, dll_rst, ap_pulse, pd_exit_slow, err_test, err_rsvd;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ddr2_mrs_ctrl #(.LOCK_CYC(LOCK)) u0 (
        .clk(clk), .rst_n(rst_n), .mr_we(mr_we), .mr_val(mr_val),
        .rd_req(rd_req), .wap_req(wap_req), .burst_end(burst_end), .act_pd(act_pd),
        .rd_allow(rd_allow), .rd_go(rd_go), .dll_rst(dll_rst), .ap_pulse(ap_pulse),
        .pd_exit_slow(pd_exit_slow), .err_test(err_test), .err_rsvd(err_rsvd)
    );

    // {mode value, expected WR clocks, err_rsvd, err_test, pd_exit_slow with act_pd=1}
    localparam logic [18:0] VEC [8] = '{
        {13'h0600, 3'd4, 1'b0, 1'b0, 1'b0},
        {13'h0000, 3'd4, 1'b1, 1'b0, 1'b0},
        {13'h1A00, 3'd6, 1'b0, 1'b0, 1'b1},
        {13'h0E00, 3'd6, 1'b1, 1'b0, 1'b0},
        {13'h1480, 3'd6, 1'b1, 1'b1, 1'b0},
        {13'h0200, 3'd2, 1'b0, 1'b0, 1'b0},
        {13'h1C00, 3'd2, 1'b1, 1'b0, 1'b1},
        {13'h0400, 3'd3, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_mr(input logic [12:0] v, output int at);
        @(negedge clk);
        mr_we = 1'b1;
        mr_val = v;
        @(negedge clk);
        mr_we = 1'b0;
        at = cyc;
    endtask

    task automatic measure_ap(input bit arm, output int k, output int after);
        @(negedge clk);
        wap_req = arm;
        @(negedge clk);
        wap_req = 1'b0;
        burst_end = 1'b1;
        @(negedge clk);
        burst_end = 1'b0;
        k = 0;
        while (!ap_pulse && k < 12) begin
            @(negedge clk);
            k++;
        end
        @(negedge clk);
        after = int'(ap_pulse);
    endtask

    task automatic wait_rise(input int lim, output int at);
        while (!rd_allow && cyc < lim) @(negedge clk);
        at = cyc;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int w1, w2, at, k, after;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_req = 1'b1;
        act_pd = 1'b1;
        chk("R1 rd_allow", rd_allow, 0);
        chk("R1 rd_go", rd_go, 0);
        chk("R1 dll_rst", dll_rst, 0);
        chk("R1 err_test", err_test, 0);
        chk("R1 err_rsvd", err_rsvd, 0);
        chk("R1 pd_exit_slow", pd_exit_slow, 0);
        measure_ap(1'b1, k, after);
        chk("R1 reset WR clocks", k, 2);

        // R4/R5 initial DLL reset
        wr_mr(13'h0300, w1);
        chk("R4 dll_rst pulse", dll_rst, 1);
        chk("R5 rd_go blocked", rd_go, 0);
        @(negedge clk);
        chk("R4 dll_rst self-clears", dll_rst, 0);
        wait_rise(w1 + 400, at);
        chk("R5 rise edge", at - w1, LOCK + 1);
        chk("R5 rd_go granted", rd_go, 1);

        // R2 test-mode write with bit 8 starts no DLL reset
        wr_mr(13'h0180, w2);
        chk("R2 err_test set", err_test, 1);
        chk("R2 no dll_rst", dll_rst, 0);
        chk("R2 rd_allow kept", rd_allow, 1);

        // vector table: R3 R7 R8 R2 R10
        for (int i = 0; i < 8; i++) begin
            wr_mr(VEC[i][18:6], w2);
            chk($sformatf("R8 err_rsvd vec%0d", i), err_rsvd, int'(VEC[i][2]));
            chk($sformatf("R3 err_test vec%0d", i), err_test, int'(VEC[i][1]));
            chk($sformatf("R10 pd_exit_slow vec%0d", i), pd_exit_slow, int'(VEC[i][0]));
            measure_ap(1'b1, k, after);
            chk($sformatf("R7 WR clocks vec%0d", i), k, int'(VEC[i][5:3]));
            chk($sformatf("R7 ap single vec%0d", i), after, 0);
        end

        // R10 precharge power-down ignores bit 12
        wr_mr(13'h1200, w2);
        chk("R10 active pd slow", pd_exit_slow, 1);
        act_pd = 1'b0;
        @(negedge clk);
        chk("R10 precharge pd", pd_exit_slow, 0);
        act_pd = 1'b1;

        // R9 burst end without pending request
        measure_ap(1'b0, k, after);
        chk("R9 no ap_pulse", k, 12);

        // R6 restart with bit 8 during the wait
        wr_mr(13'h0300, w1);
        repeat (100) @(negedge clk);
        wr_mr(13'h0300, w2);
        wait_rise(w2 + 400, at);
        chk("R6 restart rise", at - w2, LOCK + 1);

        // R6 no restart without bit 8
        wr_mr(13'h0300, w1);
        repeat (50) @(negedge clk);
        wr_mr(13'h0400, w2);
        wait_rise(w1 + 400, at);
        chk("R6 no-restart rise", at - w1, LOCK + 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule